// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small 8-bit microcoded processor. It keeps the current opcode in a two-stage instruction register and counts micro-steps with a 4-bit step counter. The opcode and the step together address a combinational microcode table, which produces a 32-bit control word for the datapath. The datapath itself is outside the block: its registers, bus, ALU and memory.

The control word changes only on the falling clock edge. The registers it drives load on the next rising edge. The first instruction-register stage takes the data bus on a rising edge while the control word asks for an instruction write. The second stage copies the first on the falling edge, the same edge on which the step counter moves. Because of this, the opcode and step bits of the microcode address always change together.

An instruction ends as soon as its last step carries the next-instruction bit. That bit reloads the step counter to zero synchronously. The first two steps of every instruction are the same, so a new instruction's fetch can run while the previous opcode is still in the second stage. The table holds the fetch steps and three sample opcodes: no-op, immediate accumulator load and set-carry.

Top module: `cseq_top`

## Requirements
- R1: While rst_n is low at a clock edge (either edge), the block clears both instruction-register stages and the step counter. Outputs then read step 0, opcode 0x00 and control word 0x00000003.
- R2: For every opcode, step 0 produces control word 0x00000003: bit 0 drives the program counter onto the bus and bit 1 writes the memory address register. Step 1 produces 0x0000001C: bit 2 reads RAM, bit 3 writes the instruction register and bit 4 increments the program counter.
- R3: The first instruction-register stage captures data_bus at a rising edge only when control bit 3 is set. Bus values presented at any other step have no effect on the opcode.
- R4: opcode_out changes only on a falling edge, where it takes the first stage's value. An opcode fetched in step 1 therefore appears in the same cycle that the step becomes 2.
- R5: On each falling edge the step counter loads 0 if control bit 5 (next-instruction) is set. Otherwise it increments by one.
- R6: With next-instruction clear, step 15 is followed by step 0.
- R7: Opcode 0x00 (no-op) gives control word 0x00000020 at step 2 and lasts 3 cycles.
- R8: Opcode 0x01 (immediate load) gives 0x00000003 at step 2. At step 3 it gives 0x000000F4: RAM read, bit 6 for the N/Z flag update, bit 7 for the A/H write, program-counter increment and next-instruction. It lasts 4 cycles.
- R9: Opcode 0x02 (set-carry) gives 0x00000720 at step 2: bit 8 for the ALU carry input, bit 9 for the carry-flag load, bit 10 for the ALU read, and next-instruction. It lasts 3 cycles.
- R10: Every other opcode gives an all-zero control word at steps 2 to 15 and so lasts 16 cycles.
- R11: The control word is the same just before and just after each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge loads stage one, falling edge moves step and stage two |
| rst_n | input | 1 | Synchronous active-low reset, sampled on both edges |
| data_bus | input | 8 | Shared data bus carrying fetched opcodes |
| ctrl_word | output | 32 | Control word for the current step |
| step_out | output | 4 | Current micro-step |
| opcode_out | output | 8 | Opcode addressing the microcode (second stage) |

## Verification
The bench builds the block with its default parameters: 8-bit opcodes, a 4-bit step and a 32-bit control word. With these, a sweep through all 256 opcodes takes only a few thousand cycles, so every table entry is checked. The 4-bit step also brings the step-15 wrap within reach, because each undefined opcode runs all sixteen steps. A cycle-level model in the bench follows the step, both register stages and the expected control word. It feeds junk on the bus outside step 1, and it asserts reset partway through an instruction.

// File: rtl/cseq_pkg.sv
// Shared constants for the control sequencer: control-word bit positions
// and the opcodes the microcode table defines.
package cseq_pkg;
    localparam int CW_PC_OUT   = 0;
    localparam int CW_MAR_WR   = 1;
    localparam int CW_RAM_RD   = 2;
    localparam int CW_IR_WR    = 3;
    localparam int CW_PC_INC   = 4;
    localparam int CW_NEXT     = 5;
    localparam int CW_FLAG_NZ  = 6;
    localparam int CW_AH_WR    = 7;
    localparam int CW_CARRY_IN = 8;
    localparam int CW_FLAG_C   = 9;
    localparam int CW_ALU_RD   = 10;
    localparam int CW_USED     = 11;

    localparam logic [7:0] OPC_NOP  = 8'h00;
    localparam logic [7:0] OPC_LDI  = 8'h01;
    localparam logic [7:0] OPC_SETC = 8'h02;
endpackage

// File: rtl/cseq_instr_reg.sv
// Two-stage instruction register. Stage one captures the bus on the rising
// edge when load is set; stage two copies stage one on the falling edge so
// the microcode address changes only with the step counter.
// Assumes rst_n is held across at least one edge of each polarity.
module cseq_instr_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] bus,
    output logic [W-1:0] cur
);
    logic [W-1:0] held;

    // Stage one: capture the fetched opcode on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (load) held <= bus;
    end

    // Stage two: present the opcode to the microcode on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) cur <= '0;
        else        cur <= held;
    end
endmodule

// File: rtl/cseq_step_ctr.sv
// Micro-step counter advanced on the falling edge. A restart request loads
// zero synchronously; otherwise it counts up and wraps at its width.
module cseq_step_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] step
);
    // Advance, restart or clear the step on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n)       step <= '0;
        else if (restart) step <= '0;
        else              step <= step + 1'b1;
    end
endmodule

// File: rtl/cseq_ucode_rom.sv
// Combinational microcode table indexed by opcode and step. Steps 0 and 1
// are the shared fetch; later steps depend on the opcode, and undefined
// entries yield an all-zero control word. Assumes CW_W >= CW_USED.
module cseq_ucode_rom
    import cseq_pkg::*;
#(
    parameter int OP_W   = 8,
    parameter int STEP_W = 4,
    parameter int CW_W   = 32
) (
    input  logic [OP_W-1:0]   opcode,
    input  logic [STEP_W-1:0] step,
    output logic [CW_W-1:0]   cw
);
    localparam logic [OP_W-1:0] K_NOP  = OP_W'(OPC_NOP);
    localparam logic [OP_W-1:0] K_LDI  = OP_W'(OPC_LDI);
    localparam logic [OP_W-1:0] K_SETC = OP_W'(OPC_SETC);

    // Decode the control word for the current opcode and step.
    always_comb begin
        cw = '0;
        if (step == STEP_W'(0)) begin
            cw[CW_PC_OUT] = 1'b1;
            cw[CW_MAR_WR] = 1'b1;
        end else if (step == STEP_W'(1)) begin
            cw[CW_RAM_RD] = 1'b1;
            cw[CW_IR_WR]  = 1'b1;
            cw[CW_PC_INC] = 1'b1;
        end else begin
            case (opcode)
                K_NOP: begin
                    if (step == STEP_W'(2)) cw[CW_NEXT] = 1'b1;
                end
                K_LDI: begin
                    if (step == STEP_W'(2)) begin
                        cw[CW_PC_OUT] = 1'b1;
                        cw[CW_MAR_WR] = 1'b1;
                    end else if (step == STEP_W'(3)) begin
                        cw[CW_RAM_RD]  = 1'b1;
                        cw[CW_FLAG_NZ] = 1'b1;
                        cw[CW_AH_WR]   = 1'b1;
                        cw[CW_PC_INC]  = 1'b1;
                        cw[CW_NEXT]    = 1'b1;
                    end
                end
                K_SETC: begin
                    if (step == STEP_W'(2)) begin
                        cw[CW_CARRY_IN] = 1'b1;
                        cw[CW_FLAG_C]   = 1'b1;
                        cw[CW_ALU_RD]   = 1'b1;
                        cw[CW_NEXT]     = 1'b1;
                    end
                end
                default: cw = '0;
            endcase
        end
    end
endmodule

// File: rtl/cseq_top.sv
// Control sequencer top: ties the two-stage instruction register, the step
// counter and the microcode table together. The control word feeds back to
// load the instruction register and to restart the step counter.
module cseq_top
    import cseq_pkg::*;
#(
    parameter int OP_W   = 8,
    parameter int STEP_W = 4,
    parameter int CW_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   data_bus,
    output logic [CW_W-1:0]   ctrl_word,
    output logic [STEP_W-1:0] step_out,
    output logic [OP_W-1:0]   opcode_out
);
    logic [CW_W-1:0]   cw;
    logic [STEP_W-1:0] step;
    logic [OP_W-1:0]   opcode;

    cseq_instr_reg #(.W(OP_W)) u_ir (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cw[CW_IR_WR]),
        .bus   (data_bus),
        .cur   (opcode)
    );

    cseq_step_ctr #(.W(STEP_W)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cw[CW_NEXT]),
        .step    (step)
    );

    cseq_ucode_rom #(.OP_W(OP_W), .STEP_W(STEP_W), .CW_W(CW_W)) u_rom (
        .opcode (opcode),
        .step   (step),
        .cw     (cw)
    );

    assign ctrl_word  = cw;
    assign step_out   = step;
    assign opcode_out = opcode;
endmodule

// File: rtl/cseq_checker.sv
// Temporal checks on the sequencer ports, bound into every cseq_top.
module cseq_checker
    import cseq_pkg::*;
#(
    parameter int OP_W   = 8,
    parameter int STEP_W = 4,
    parameter int CW_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW_W-1:0]   cw,
    input logic [STEP_W-1:0] step,
    input logic [OP_W-1:0]   opcode
);
    localparam logic [CW_W-1:0] FETCH0 = CW_W'(3);

    // R5: counter advances by one when next-instruction is clear
    a_r5_step_advance: assert property (@(negedge clk) disable iff (!rst_n)
        (!cw[CW_NEXT] && step != '1) |=> step == $past(step) + 1'b1);

    // R5: next-instruction reloads step zero
    a_r5_next_restart: assert property (@(negedge clk) disable iff (!rst_n)
        cw[CW_NEXT] |=> step == '0);

    // R6: wrap from the last step
    a_r6_wrap: assert property (@(negedge clk) disable iff (!rst_n)
        (!cw[CW_NEXT] && step == '1) |=> step == '0);

    // R4: opcode may only move on the edge that ends step 1
    a_r4_opcode_hold: assert property (@(negedge clk) disable iff (!rst_n)
        (step != STEP_W'(1)) |=> $stable(opcode));

    // R2: step 0 is the shared fetch word
    a_r2_fetch_word: assert property (@(posedge clk) disable iff (!rst_n)
        (step == '0) |-> cw == FETCH0);

    // R8: immediate load ends at step 3
    a_r8_ldi_end: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_W'(3) && opcode == OP_W'(OPC_LDI)) |-> cw[CW_NEXT]);
endmodule

bind cseq_top cseq_checker #(.OP_W(OP_W), .STEP_W(STEP_W), .CW_W(CW_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cw     (ctrl_word),
    .step   (step_out),
    .opcode (opcode_out)
);

// File: tb/cseq_top_test.sv
// Self-checking bench: a cycle model tracks step, both register stages
// and the expected control word while every opcode is swept.
module cseq_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus = 8'h00;
    logic [31:0] ctrl_word;
    logic [3:0]  step_out;
    logic [7:0]  opcode_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [3:0]  m_step;
    logic [7:0]  m_ir1;
    logic [7:0]  m_op;
    bit          m_wrapped;

    cseq_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_bus   (bus),
        .ctrl_word  (ctrl_word),
        .step_out   (step_out),
        .opcode_out (opcode_out)
    );

    always #5 clk = ~clk;

    // Expected control word from the requirement values.
    function automatic logic [31:0] exp_cw(input logic [7:0] op, input logic [3:0] st);
        if (st == 4'd0) return 32'h0000_0003;
        if (st == 4'd1) return 32'h0000_001C;
        case (op)
            8'h00: return (st == 4'd2) ? 32'h0000_0020 : 32'h0;
            8'h01: return (st == 4'd2) ? 32'h0000_0003 :
                          (st == 4'd3) ? 32'h0000_00F4 : 32'h0;
            8'h02: return (st == 4'd2) ? 32'h0000_0720 : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string cw_tag(input logic [7:0] op, input logic [3:0] st);
        if (st < 4'd2) return "R2";
        if (op == 8'h00) return "R7";
        if (op == 8'h01) return "R8";
        if (op == 8'h02) return "R9";
        return "R10";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Enter and leave reset; ends at falling edge + 2.
    task automatic do_reset();
        @(negedge clk); #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        check("R1", "step in reset", 32'(step_out), 32'h0);
        check("R1", "opcode in reset", 32'(opcode_out), 32'h0);
        check("R1", "cw in reset", ctrl_word, 32'h3);
        @(negedge clk); #2 rst_n = 1'b1;
        m_step = 4'd0; m_ir1 = 8'h00; m_op = 8'h00; m_wrapped = 1'b0;
    endtask

    // One clock cycle, entered and left at falling edge + 2.
    task automatic run_cycle(input logic [7:0] next_op);
        logic [31:0] pre;
        logic [31:0] e;
        bus = (m_step == 4'd1) ? next_op : (next_op ^ 8'hA5);
        #1 pre = ctrl_word;
        @(posedge clk); #2;
        e = exp_cw(m_op, m_step);
        check(m_wrapped ? "R6" : "R5", "step", 32'(step_out), 32'(m_step));
        check((m_step == 4'd2) ? "R3" : "R4", "opcode", 32'(opcode_out), 32'(m_op));
        check(cw_tag(m_op, m_step), "control word", ctrl_word, e);
        check("R11", "cw across rising edge", ctrl_word, pre);
        if (e[3]) m_ir1 = bus;
        m_wrapped = (!e[5] && m_step == 4'hF);
        m_step = e[5] ? 4'd0 : m_step + 4'd1;
        m_op = m_ir1;
        @(negedge clk); #2;
    endtask

    // Fetch and execute one instruction, checking its cycle count.
    task automatic run_instr(input logic [7:0] op);
        int n = 0;
        string tag;
        int exp_len;
        do begin run_cycle(op); n++; end while (m_step != 4'd2);
        do begin run_cycle(op); n++; end while (m_step != 4'd0);
        case (op)
            8'h00: begin tag = "R7"; exp_len = 3; end
            8'h01: begin tag = "R8"; exp_len = 4; end
            8'h02: begin tag = "R9"; exp_len = 3; end
            default: begin tag = "R10"; exp_len = 16; end
        endcase
        check(tag, "instruction length", 32'(n), 32'(exp_len));
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < 256; i++) run_instr(8'(i));
        run_instr(8'h01); run_instr(8'h02); run_instr(8'h00);
        run_instr(8'h01); run_instr(8'h01); run_instr(8'h02);
        // R1: reset in the middle of an instruction
        for (int k = 0; k < 3; k++) run_cycle(8'h01);
        do_reset();
        run_instr(8'h02);
        run_instr(8'h7E);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule